// File: doc/BRIEF.md
# Synchronous Serial ADC Interface Controller

This block is a serial master that sets up and reads an external analog-to-digital converter. Software writes one 16-bit control word through a plain write port. The word carries three things: the configuration byte the converter needs, the number of shift clocks in the frame, and two flags. One flag starts a transfer. The other gates a free-running sample clock.

When a transfer starts, the block raises a frame sync for the first half shift period. It then produces the shift clock from a fixed divider of the system clock. The configuration byte goes out most significant bit first and the data line then stays low. On every rising shift clock the block samples the converter's serial output into a 16-bit receive register. The busy flag stays high for the whole frame. When the frame completes, an end-of-transfer interrupt latches, and a read of the receive data clears it.

A write with the start flag low changes only the sample-clock gate, so the sample clock can be switched on or off without running a frame.

Top module: `ssadc_ctrl`

## Requirements
- R1: Control word decoding. Bits 7:0 hold the configuration byte, bits 12:8 the frame length, bit 13 the sample-clock enable and bit 14 the start flag. Bit 15 has no effect.
- R2: During shift clock k of a frame (k counted from 0), the serial output is configuration bit 7-k for k < 8, and 0 for k >= 8. It is 0 whenever the block is idle.
- R3: A frame of length N gives exactly N shift clock pulses. Each pulse is HALF_DIV system cycles low followed by HALF_DIV cycles high, starting low. The shift clock is low when idle.
- R4: Frame sync is high for exactly the first HALF_DIV system cycles after the start write, which is the low half of the first shift clock, and low at all other times.
- R5: On each low-to-high shift clock edge, the serial input is shifted into bit 0 of the receive register and older bits move up. The read data always shows the last 16 bits captured, and it changes at no other time.
- R6: Busy rises at the clock edge that accepts a start write with N > 0 and stays high for 2*HALF_DIV*N system cycles.
- R7: The interrupt latches high at the edge where busy falls. It clears on the edge of a read strobe. A completion on the same edge as a read wins.
- R8: A write with the start flag low starts no frame, but it updates the sample-clock enable.
- R9: A start write while busy is ignored, and the frame in progress finishes unchanged.
- R10: A start write with frame length 0 gives no shift clock and no busy. It sets the interrupt on the same edge and leaves the receive register unchanged.
- R11: The sample clock output runs freely from reset, toggling every HALF_DIV system cycles, and is forced low while its enable is clear.
- R12: After reset, every output is 0 and the receive data is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 16 | Control word |
| rd_en | input | 1 | Receive data read strobe (clears interrupt) |
| rd_data | output | 16 | Receive register |
| busy | output | 1 | Frame in progress |
| eot_irq | output | 1 | End-of-transfer interrupt |
| ser_clk | output | 1 | Shift clock to the converter |
| ser_sync | output | 1 | Frame sync pulse |
| ser_out | output | 1 | Serial data to the converter |
| ser_in | input | 1 | Serial data from the converter |
| smp_clk | output | 1 | Gated free-running sample clock |

## Verification
The bench targets these corner cases:
- Frames of length 1, 8, 25 and 31. A design that miscounts would show an extra or missing clock, or keep sending configuration bits after the eighth.
- A start write during a busy frame. A design that accepts it would restart the frame or reload the byte in the middle of it.
- A zero-length start. A design that gets it wrong would hang busy, miss the interrupt, or shift in a stray bit.
- A settings-only write. A design that gets it wrong would start a frame or ignore the sample-clock gate.
- Reads placed both after completions and during idle time. A design that gets these wrong would leave the interrupt stuck or clear it on its own.

// File: rtl/ssadc_pkg.sv
package ssadc_pkg;
   localparam int CFG_W   = 8;
   localparam int LEN_W   = 5;
   localparam int WORD_W  = 16;

   typedef struct packed {
      logic             rsvd;
      logic             go;
      logic             smp_en;
      logic [LEN_W-1:0] frame_len;
      logic [CFG_W-1:0] cfg_byte;
   } ctrl_word_t;

   function automatic ctrl_word_t unpack_word(input logic [WORD_W-1:0] w);
      ctrl_word_t c;
      c = ctrl_word_t'(w);
      return c;
   endfunction
endpackage

// File: rtl/ssadc_halfgen.sv
module ssadc_halfgen #(
   parameter int HALF_DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

   initial begin
      if (HALF_DIV < 1) $error("HALF_DIV must be at least 1");
   end

   generate
      if (HALF_DIV == 1) begin : g_every
         assign tick = run;
      end else begin : g_count
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                cnt_q <= '0;
            else if (!run)                             cnt_q <= '0;
            else if (cnt_q == CNT_W'(HALF_DIV - 1))    cnt_q <= '0;
            else                                       cnt_q <= cnt_q + 1'b1;
         end
         assign tick = run && (cnt_q == CNT_W'(HALF_DIV - 1));

         p_cnt_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
            !run |=> (cnt_q == '0));
      end
   endgenerate
endmodule

// File: rtl/ssadc_smpclk.sv
module ssadc_smpclk #(
   parameter int HALF_DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   output logic smp_clk
);
   localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

   logic tog_q;

   generate
      if (HALF_DIV == 1) begin : g_fast
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) tog_q <= 1'b0;
            else        tog_q <= ~tog_q;
         end
      end else begin : g_div
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
               tog_q <= 1'b0;
            end else if (cnt_q == CNT_W'(HALF_DIV - 1)) begin
               cnt_q <= '0;
               tog_q <= ~tog_q;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   endgenerate

   assign smp_clk = tog_q & enable;

   p_smp_gated_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |-> !smp_clk);
endmodule

// File: rtl/ssadc_shifter.sv
module ssadc_shifter #(
   parameter int CFG_W = 8,
   parameter int LEN_W = 5,
   parameter int RX_W  = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CFG_W-1:0] cfg_in,
   input  logic             active,
   input  logic [LEN_W-1:0] bit_idx,
   input  logic             sample,
   input  logic             sdi,
   output logic             sdo,
   output logic [RX_W-1:0]  rx_word
);
   logic [CFG_W-1:0] cfg_q;
   logic [RX_W-1:0]  rx_q;

   initial begin
      if (RX_W < 2)  $error("RX_W too small");
      if (CFG_W < 1) $error("CFG_W too small");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cfg_q <= '0;
      else if (load) cfg_q <= cfg_in;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rx_q <= '0;
      else if (sample) rx_q <= {rx_q[RX_W-2:0], sdi};
   end

   always_comb begin
      sdo = 1'b0;
      if (active && (32'(bit_idx) < CFG_W))
         sdo = cfg_q[CFG_W - 1 - 32'(bit_idx)];
   end

   assign rx_word = rx_q;

   p_rx_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !sample |=> $stable(rx_q));
   p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !load) |=> $stable(cfg_q));
   p_sdo_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !active |-> !sdo);
endmodule

// File: rtl/ssadc_ctrl.sv
module ssadc_ctrl #(
   parameter int HALF_DIV = 2,
   parameter int RX_W     = 16
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [15:0] wr_data,
   input  logic        rd_en,
   output logic [15:0] rd_data,
   output logic        busy,
   output logic        eot_irq,
   output logic        ser_clk,
   output logic        ser_sync,
   output logic        ser_out,
   input  logic        ser_in,
   output logic        smp_clk
);
   import ssadc_pkg::*;

   initial begin
      if (RX_W != WORD_W) $error("receive width must match bus width");
      if (HALF_DIV < 1)   $error("HALF_DIV must be at least 1");
   end

   ctrl_word_t       cw;
   logic             busy_q, sclk_q, sync_q, irq_q, smen_q;
   logic [LEN_W-1:0] len_q, bit_q;
   logic             tick, accept, zero_go, last_bit, done, rise;

   assign cw       = unpack_word(wr_data);
   assign accept   = wr_en && cw.go && !busy_q && (cw.frame_len != '0);
   assign zero_go  = wr_en && cw.go && !busy_q && (cw.frame_len == '0);
   assign last_bit = (bit_q == len_q - 1'b1);
   assign rise     = busy_q && tick && !sclk_q;
   assign done     = busy_q && tick && sclk_q && last_bit;

   ssadc_halfgen #(.HALF_DIV(HALF_DIV)) u_half (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (busy_q),
      .tick (tick)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         sclk_q <= 1'b0;
         sync_q <= 1'b0;
         bit_q  <= '0;
         len_q  <= '0;
      end else if (accept) begin
         busy_q <= 1'b1;
         sclk_q <= 1'b0;
         sync_q <= 1'b1;
         bit_q  <= '0;
         len_q  <= cw.frame_len;
      end else if (busy_q && tick) begin
         if (!sclk_q) begin
            sclk_q <= 1'b1;
            sync_q <= 1'b0;
         end else begin
            sclk_q <= 1'b0;
            if (last_bit) busy_q <= 1'b0;
            else          bit_q  <= bit_q + 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= (irq_q && !rd_en) || done || zero_go;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     smen_q <= 1'b0;
      else if (wr_en) smen_q <= cw.smp_en;
   end

   ssadc_shifter #(.CFG_W(CFG_W), .LEN_W(LEN_W), .RX_W(RX_W)) u_shift (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (accept),
      .cfg_in (cw.cfg_byte),
      .active (busy_q),
      .bit_idx(bit_q),
      .sample (rise),
      .sdi    (ser_in),
      .sdo    (ser_out),
      .rx_word(rd_data)
   );

   ssadc_smpclk #(.HALF_DIV(HALF_DIV)) u_smp (
      .clk    (clk),
      .rst_n  (rst_n),
      .enable (smen_q),
      .smp_clk(smp_clk)
   );

   assign busy     = busy_q;
   assign eot_irq  = irq_q;
   assign ser_clk  = sclk_q;
   assign ser_sync = sync_q;

   p_sclk_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !ser_clk);
   p_sync_first_half_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ser_sync |-> (busy && !ser_clk));
   p_irq_on_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> eot_irq);
   p_busy_keeps_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && wr_en) |=> (busy ? $stable(len_q) : 1'b1));
   p_zero_no_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      zero_go |=> (!busy && eot_irq));
endmodule

// File: tb/ssadc_ctrl_test.sv
module ssadc_ctrl_test;
   localparam int PERIOD = 10;
   localparam int HALF   = 2;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        wr_en = 1'b0, rd_en = 1'b0, ser_in = 1'b0;
   logic [15:0] wr_data = '0;
   logic [15:0] rd_data;
   logic        busy, eot_irq, ser_clk, ser_sync, ser_out, smp_clk;

   int vectors = 0, errors = 0;
   bit done_flag = 0;

   ssadc_ctrl #(.HALF_DIV(HALF)) uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_en(rd_en), .rd_data(rd_data), .busy(busy), .eot_irq(eot_irq),
      .ser_clk(ser_clk), .ser_sync(ser_sync), .ser_out(ser_out),
      .ser_in(ser_in), .smp_clk(smp_clk)
   );

   always #(PERIOD/2) clk = ~clk;

   // behavioural reference model
   int m_busy, m_irq, m_ph, m_hi, m_bit, m_len, m_fs, m_smcnt, m_smtog, m_smen;
   logic [7:0]  m_cfg;
   logic [15:0] m_rx;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_busy = 0; m_irq = 0; m_ph = 0; m_hi = 0; m_bit = 0; m_len = 0;
         m_fs = 0; m_smcnt = 0; m_smtog = 0; m_smen = 0; m_cfg = '0; m_rx = '0;
      end else begin
         int was_busy, set_irq;
         was_busy = m_busy;
         set_irq  = 0;
         if (m_smcnt == HALF - 1) begin m_smcnt = 0; m_smtog = 1 - m_smtog; end
         else m_smcnt++;
         if (m_busy != 0) begin
            if (m_ph == HALF - 1) begin
               m_ph = 0;
               if (m_hi == 0) begin
                  m_hi = 1; m_fs = 0; m_rx = {m_rx[14:0], ser_in};
               end else begin
                  m_hi = 0;
                  if (m_bit == m_len - 1) begin m_busy = 0; set_irq = 1; end
                  else m_bit++;
               end
            end else m_ph++;
         end
         if (wr_en) begin
            m_smen = wr_data[13];
            if (wr_data[14] && was_busy == 0) begin
               if (wr_data[12:8] == 0) set_irq = 1;
               else begin
                  m_busy = 1; m_ph = 0; m_hi = 0; m_bit = 0; m_fs = 1;
                  m_len = int'(wr_data[12:8]); m_cfg = wr_data[7:0];
               end
            end
         end
         if (rd_en) m_irq = 0;
         if (set_irq != 0) m_irq = 1;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s t=%0t actual=%0h expected=%0h", req, $time, act, exp);
      end
   endtask

   // compare on every clock, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done_flag) begin
         logic exp_sdo;
         exp_sdo = (m_busy != 0 && m_bit < 8) ? m_cfg[7 - m_bit] : 1'b0;
         chk("R6 busy", 32'(busy), 32'(m_busy));
         chk("R7 irq", 32'(eot_irq), 32'(m_irq));
         chk("R3 sclk", 32'(ser_clk), 32'(m_hi));
         chk("R4 sync", 32'(ser_sync), 32'(m_fs));
         chk("R1 R2 sdo", 32'(ser_out), 32'(exp_sdo));
         chk("R5 rx", 32'(rd_data), 32'(m_rx));
         chk("R11 smp", 32'(smp_clk), 32'(m_smen != 0 && m_smtog != 0));
      end
   end

   // serial input pattern
   logic [15:0] lfsr = 16'hACE1;
   always @(negedge clk) begin
      lfsr   <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      ser_in <= lfsr[0];
   end

   task automatic write_word(input logic [15:0] w);
      @(negedge clk); wr_en = 1'b1; wr_data = w;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic do_read();
      @(negedge clk); rd_en = 1'b1;
      @(negedge clk); rd_en = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [15:0] mk(input bit go, input bit sm, input int len, input logic [7:0] cfg);
      return {1'b0, go, sm, 5'(len), cfg};
   endfunction

   initial begin
      idle(3);
      // R12: reset state
      chk("R12 reset", {busy, eot_irq, ser_clk, ser_sync, ser_out, smp_clk}, 0);
      chk("R12 reset rx", 32'(rd_data), 0);
      rst_n = 1'b1;
      idle(2);

      write_word(mk(1, 0, 25, 8'hA5));
      idle(2 * HALF * 25 + 4);
      do_read();
      idle(3);

      // R8: settings-only write, sample clock on, no frame
      write_word(mk(0, 1, 12, 8'hFF));
      chk("R8 no frame", 32'(busy), 0);
      idle(12);
      write_word(mk(0, 0, 3, 8'h00));
      idle(6);

      // R9: start while busy ignored
      write_word(mk(1, 1, 31, 8'h3C));
      idle(10);
      write_word(mk(1, 1, 2, 8'hC3));
      chk("R9 still busy", 32'(busy), 1);
      idle(2 * HALF * 31);
      do_read();
      idle(3);

      // R10: zero length
      write_word(mk(1, 0, 0, 8'h81));
      chk("R10 irq no busy", {30'd0, busy, eot_irq}, 1);
      idle(4);
      do_read();

      // R1: bit 15 ignored, short frames
      write_word(16'h8000 | mk(1, 0, 1, 8'h80));
      idle(2 * HALF + 3);
      write_word(mk(1, 0, 8, 8'h5A));
      idle(2 * HALF * 8 + 3);
      do_read();
      write_word(mk(1, 0, 17, 8'h01));
      idle(2 * HALF * 17 + 3);
      idle(2);

      done_flag = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      #(PERIOD * 100000);
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule